// File: doc/BRIEF.md
# Interval Trigger Timer for a Conversion Queue

This block produces the start events for a periodically scanned conversion queue. A counter advances on each cycle where the conversion-clock enable is high. When the counter completes the interval chosen by software, the block raises a one-cycle trigger pulse and clears the counter. Two queue modes use the timer. Continuous periodic mode fires on every interval with no further software action. One-shot interval mode fires once for each arming of its scan-enable bit, and the bit clears itself when the trigger fires.

The block holds the counter at zero in several cases:
- The queue mode is one that does not use the timer.
- One-shot mode is selected but its scan enable is not set.
- Freeze or stop is requested.
- Reset is asserted.

The counter also restarts from zero for one cycle in two cases: after each completed interval, and when software moves the queue from one timer mode to the other. Stop clears the whole configuration register. The timer then stays idle until software writes a timer mode again.

Configuration comes from a simple write port that carries the mode, the interval select and the scan enable. The current mode and scan enable are visible as outputs for the queue sequencer.

Top module: `pit_trigger_timer`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `trig_o` is 0, `mode_o` is 0 and `scan_en_o` is 0.
- R2: In periodic mode (mode code 5), with interval select s, the trigger fires after every 2^(MIN_EXP+s) enabled ticks. Counting starts at the first tick after the write edge, so with `tick_i` held high the first pulse is seen in the cycle after the 2^(MIN_EXP+s)-th following clock edge. Each pulse is exactly one cycle wide.
- R3: An interval select greater than NUM_SEL-1 behaves as NUM_SEL-1.
- R4: The counter advances only on cycles where `tick_i` is 1. With one tick every N cycles, the steady trigger spacing is N·2^(MIN_EXP+s) cycles.
- R5: Mode codes 0, 1, 2, 3, 6 and 7 do not use the timer. In these modes the counter is held at zero and no trigger is issued.
- R6: In one-shot mode (mode code 4) with scan enable 0, the counter is held at zero and no trigger is issued.
- R7: In one-shot mode with scan enable 1, a single trigger is issued after 2^(MIN_EXP+s) ticks, and `scan_en_o` is 0 from that trigger cycle on. Writing the enable to 1 again re-arms one more interval.
- R8: While `freeze_i` is 1, no trigger is issued, the counter is held at zero and the mode is kept. After release, the next trigger comes a full interval after release.
- R9: A cycle with `stop_i` at 1 clears mode, select and scan enable, and writes during stop are ignored. After stop, no trigger is issued until a timer mode is written.
- R10: A write that changes the mode from one timer mode to the other restarts the counter from zero. A write that keeps the same mode leaves the running count undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Conversion-clock enable; one count per high cycle |
| cfg_we_i | input | 1 | Write strobe for the configuration register |
| cfg_mode_i | input | 3 | Queue mode code to write |
| cfg_sel_i | input | SEL_W | Interval select to write |
| cfg_scan_en_i | input | 1 | One-shot scan enable to write |
| stop_i | input | 1 | Stop request; holds the counter and clears the configuration |
| freeze_i | input | 1 | Freeze request; holds the counter |
| trig_o | output | 1 | One-cycle queue trigger |
| mode_o | output | 3 | Current queue mode code |
| scan_en_o | output | 1 | Current one-shot scan enable |

## Verification
The checker watches several properties on every cycle:
- No trigger lasts longer than one cycle.
- No trigger follows a cycle without a tick, or a cycle with stop or freeze.
- No trigger is issued while the mode is idle or the one-shot mode is unarmed.
- Stop always leaves the configuration cleared.
- A one-shot trigger always disarms the enable.

Only the bench scenarios can show the exact interval lengths, the clamping of the select, the restart after freeze, and the difference between a restart on a mode change and a same-mode rewrite that leaves the count running. It shows these by sweeping every select of a small configuration and measuring gaps between triggers.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    QM_OFF      = 3'd0,
    QM_SW       = 3'd1,
    QM_EXT      = 3'd2,
    QM_EXT_CONT = 3'd3,
    QM_ONESHOT  = 3'd4,
    QM_PERIODIC = 3'd5,
    QM_RSV6     = 3'd6,
    QM_RSV7     = 3'd7
  } qmode_e;

  function automatic logic uses_timer(input logic [MODE_W-1:0] m);
    return (m == QM_ONESHOT) || (m == QM_PERIODIC);
  endfunction
endpackage

// File: rtl/pit_cfg_reg.sv
module pit_cfg_reg
  import pit_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              scan_en_i,
  input  logic              shot_done_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              scan_en_o
);
  logic [MODE_W-1:0] mode_q;
  logic [SEL_W-1:0]  sel_q;
  logic              scan_en_q;

  // stop wipes everything; a write beats the one-shot self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= QM_OFF;
      sel_q     <= '0;
      scan_en_q <= 1'b0;
    end else if (stop_i) begin
      mode_q    <= QM_OFF;
      sel_q     <= '0;
      scan_en_q <= 1'b0;
    end else if (we_i) begin
      mode_q    <= mode_i;
      sel_q     <= sel_i;
      scan_en_q <= scan_en_i;
    end else if (shot_done_i) begin
      scan_en_q <= 1'b0;
    end
  end

  assign mode_o    = mode_q;
  assign sel_o     = sel_q;
  assign scan_en_o = scan_en_q;
endmodule

// File: rtl/pit_run_ctrl.sv
module pit_run_ctrl
  import pit_pkg::*;
(
  input  logic [MODE_W-1:0] mode_q_i,
  input  logic              scan_en_q_i,
  input  logic              stop_i,
  input  logic              freeze_i,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_wr_i,
  output logic              hold_o,
  output logic              restart_o,
  output logic              oneshot_o
);
  logic cur_timer;
  logic new_timer;
  logic unarmed;

  always_comb begin
    cur_timer = uses_timer(mode_q_i);
    new_timer = uses_timer(mode_wr_i);
    oneshot_o = (mode_q_i == QM_ONESHOT);
    unarmed   = oneshot_o && !scan_en_q_i;
    hold_o    = stop_i || freeze_i || !cur_timer || unarmed;
    // timer-to-other-timer switch gives a one-cycle counter clear
    restart_o = we_i && !stop_i && cur_timer && new_timer && (mode_wr_i != mode_q_i);
  end
endmodule

// File: rtl/pit_interval_cnt.sv
module pit_interval_cnt #(
  parameter int unsigned MIN_EXP = 7,
  parameter int unsigned NUM_SEL = 11,
  parameter int unsigned SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             roll_o,
  output logic             trig_o
);
  localparam int unsigned CNT_W = MIN_EXP + NUM_SEL - 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_SEL - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_SEL-1:0] span_end;
  logic [SEL_W-1:0]   sel_eff;
  logic               at_end;
  logic               trig_q;

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_span
    assign span_end[k] = &cnt_q[MIN_EXP+k-1:0];
  end

  always_comb begin
    sel_eff = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
    at_end  = 1'b0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (sel_eff == SEL_W'(k)) at_end = span_end[k];
    end
    roll_o = tick_i && !hold_i && !restart_i && at_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= roll_o;
      if (hold_i || restart_i) cnt_q <= '0;
      else if (tick_i)         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/pit_trigger_timer.sv
module pit_trigger_timer
  import pit_pkg::*;
#(
  parameter int unsigned MIN_EXP = 7,
  parameter int unsigned NUM_SEL = 11,
  parameter int unsigned SEL_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic              cfg_scan_en_i,
  input  logic              stop_i,
  input  logic              freeze_i,
  output logic              trig_o,
  output logic [2:0]        mode_o,
  output logic              scan_en_o
);
  logic [MODE_W-1:0] mode_q;
  logic [SEL_W-1:0]  sel_q;
  logic              scan_en_q;
  logic              hold;
  logic              restart;
  logic              oneshot;
  logic              roll;
  logic              shot_done;

  assign shot_done = roll && oneshot;

  pit_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_i      (stop_i),
    .we_i        (cfg_we_i),
    .mode_i      (cfg_mode_i),
    .sel_i       (cfg_sel_i),
    .scan_en_i   (cfg_scan_en_i),
    .shot_done_i (shot_done),
    .mode_o      (mode_q),
    .sel_o       (sel_q),
    .scan_en_o   (scan_en_q)
  );

  pit_run_ctrl u_ctrl (
    .mode_q_i    (mode_q),
    .scan_en_q_i (scan_en_q),
    .stop_i      (stop_i),
    .freeze_i    (freeze_i),
    .we_i        (cfg_we_i),
    .mode_wr_i   (cfg_mode_i),
    .hold_o      (hold),
    .restart_o   (restart),
    .oneshot_o   (oneshot)
  );

  pit_interval_cnt #(
    .MIN_EXP (MIN_EXP),
    .NUM_SEL (NUM_SEL),
    .SEL_W   (SEL_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .hold_i    (hold),
    .restart_i (restart),
    .sel_i     (sel_q),
    .roll_o    (roll),
    .trig_o    (trig_o)
  );

  assign mode_o    = mode_q;
  assign scan_en_o = scan_en_q;
endmodule

// File: rtl/pit_trigger_timer_chk.sv
module pit_trigger_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       cfg_we_i,
  input logic       stop_i,
  input logic       freeze_i,
  input logic       trig_o,
  input logic [2:0] mode_o,
  input logic       scan_en_o
);
  logic idle_mode;
  assign idle_mode = !((mode_o == 3'd4) || (mode_o == 3'd5)) ||
                     ((mode_o == 3'd4) && !scan_en_o);

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  assert_tick_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(tick_i && !stop_i && !freeze_i));

  // covers R5 and R6
  assert_idle_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_mode |=> !trig_o);

  assert_oneshot_disarm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && $past(mode_o == 3'd4 && !cfg_we_i)) |-> !scan_en_o);

  assert_stop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> (mode_o == 3'd0 && !scan_en_o));
endmodule

bind pit_trigger_timer pit_trigger_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .cfg_we_i  (cfg_we_i),
  .stop_i    (stop_i),
  .freeze_i  (freeze_i),
  .trig_o    (trig_o),
  .mode_o    (mode_o),
  .scan_en_o (scan_en_o)
);

// File: tb/pit_trigger_timer_tb.sv
module pit_trigger_timer_tb;
  localparam int MIN_EXP = 2;
  localparam int NUM_SEL = 4;
  localparam int SEL_W   = 4;
  localparam int M_ONE   = 4;
  localparam int M_PER   = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_mode_i = '0;
  logic [SEL_W-1:0] cfg_sel_i = '0;
  logic       cfg_scan_en_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       freeze_i = 1'b0;
  logic       trig_o;
  logic [2:0] mode_o;
  logic       scan_en_o;

  int checks = 0;
  int fails  = 0;
  int tick_div = 1;

  always #2 clk_i = ~clk_i;

  pit_trigger_timer #(.MIN_EXP(MIN_EXP), .NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_dut (
    .clk_i, .rst_ni, .tick_i, .cfg_we_i, .cfg_mode_i, .cfg_sel_i,
    .cfg_scan_en_i, .stop_i, .freeze_i, .trig_o, .mode_o, .scan_en_o
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk_i);
      ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
      tick_i = (ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr(input int m, input int s, input bit en);
    cfg_we_i = 1'b1;
    cfg_mode_i = 3'(m);
    cfg_sel_i = SEL_W'(s);
    cfg_scan_en_i = en;
  endtask

  task automatic wait_trig(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      nx();
      if (trig_o) begin n = i; return; end
    end
  endtask

  task automatic count_trigs(input int len, output int hits);
    hits = 0;
    for (int i = 0; i < len; i++) begin
      nx();
      if (trig_o) hits++;
    end
  endtask

  function automatic int per(input int s);
    int e;
    e = (s > NUM_SEL - 1) ? NUM_SEL - 1 : s;
    return 1 << (MIN_EXP + e);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int h;
    repeat (3) @(negedge clk_i);
    chk("R1 trig in reset", int'(trig_o), 0);
    rst_ni = 1'b1;
    nx();
    chk("R1 trig", int'(trig_o), 0);
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 scan_en", int'(scan_en_o), 0);

    // R2 / R3 sweep over all selects plus out-of-range ones
    for (int s = 0; s < 16; s++) begin
      if (s >= NUM_SEL && s != 8 && s != 15) continue;
      wr(0, 0, 0); nx();
      wr(M_PER, s, 0);
      wait_trig(200, n);
      chk((s < NUM_SEL) ? "R2 first gap" : "R3 first gap", n, per(s) + 1);
      nx();
      chk("R2 pulse width", int'(trig_o), 0);
      for (int g = 0; g < 3; g++) begin
        wait_trig(200, n);
        chk((s < NUM_SEL) ? "R2 steady gap" : "R3 steady gap", n, per(s) - (g == 0 ? 1 : 0));
      end
    end

    // R4 tick gating, one tick in three
    wr(0, 0, 0); nx();
    tick_div = 3;
    wr(M_PER, 1, 0);
    wait_trig(200, n);
    for (int g = 0; g < 2; g++) begin
      wait_trig(200, n);
      chk("R4 gated gap", n, 3 * per(1));
    end
    tick_div = 1;
    nx();

    // R5 non-timer modes
    for (int m = 0; m < 8; m++) begin
      if (m == M_ONE || m == M_PER) continue;
      wr(m, 0, 1);
      count_trigs(70, h);
      chk("R5 no trigger", h, 0);
    end

    // R6 unarmed one-shot, R7 armed one-shot
    wr(M_ONE, 0, 0);
    count_trigs(40, h);
    chk("R6 unarmed silent", h, 0);
    wr(M_ONE, 0, 1);
    wait_trig(100, n);
    chk("R7 oneshot gap", n, per(0) + 1);
    chk("R7 enable cleared", int'(scan_en_o), 0);
    count_trigs(40, h);
    chk("R7 single trigger", h, 0);
    wr(M_ONE, 0, 1);
    wait_trig(100, n);
    chk("R7 rearm gap", n, per(0) + 1);

    // R8 freeze mid-interval
    wr(0, 0, 0); nx();
    wr(M_PER, 2, 0);
    wait_trig(100, n);
    repeat (7) nx();
    freeze_i = 1'b1;
    count_trigs(40, h);
    chk("R8 frozen silent", h, 0);
    chk("R8 mode kept", int'(mode_o), M_PER);
    freeze_i = 1'b0;
    wait_trig(100, n);
    chk("R8 restart gap", n, per(2));

    // R9 stop
    repeat (3) nx();
    stop_i = 1'b1;
    nx();
    chk("R9 mode cleared", int'(mode_o), 0);
    wr(M_PER, 0, 1);
    nx();
    chk("R9 write ignored", int'(mode_o), 0);
    chk("R9 enable cleared", int'(scan_en_o), 0);
    stop_i = 1'b0;
    count_trigs(70, h);
    chk("R9 idle after stop", h, 0);
    wr(M_PER, 0, 0);
    wait_trig(100, n);
    chk("R9 resume gap", n, per(0) + 1);

    // R10 timer-to-timer switch vs same-mode rewrite
    wr(0, 0, 0); nx();
    wr(M_PER, 2, 0);
    wait_trig(100, n);
    repeat (9) nx();
    wr(M_PER, 2, 0);
    wait_trig(100, n);
    chk("R10 same mode undisturbed", n, per(2) - 9);
    repeat (9) nx();
    wr(M_ONE, 2, 1);
    wait_trig(100, n);
    chk("R10 switch restart", n, per(2) + 1);

    // R1 asynchronous reset mid-run
    wr(M_PER, 0, 0);
    repeat (3) nx();
    rst_ni = 1'b0;
    #1;
    chk("R1 async trig", int'(trig_o), 0);
    chk("R1 async mode", int'(mode_o), 0);
    nx();
    rst_ni = 1'b1;
    count_trigs(30, h);
    chk("R1 idle after reset", h, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule